// File: doc/BRIEF.md
# Field-Dropping Video Sync Gate

This block sits between a video digitizer's raw timing outputs and the local video input port of a graphics controller. It takes the digitizer's horizontal reset, vertical reset, active-video, field-parity, data-valid and clock-qualifier strobes. All of them are sampled in the pixel clock domain. From these it produces a horizontal sync, a vertical sync and a line clock for the graphics side. It also drives the digitizer's active-low output enable.

A two-bit arming code from the graphics controller switches the path on. While the path is armed, only fields of one chosen parity reach the graphics port. Fields of the other parity are blanked completely. The downstream port therefore sees progressive half-frames at half the incoming field rate, about 30 Hz from a 60 Hz source with roughly 240 lines each, and interlace combing is avoided. A change of the arming code reaches the sync outputs only at the next vertical reset, so a field is never cut short. The output enable follows the code without waiting, because the digitizer's timing pins stay in high impedance until that enable is asserted.

Top module: `field_drop_sync_gate`

## Requirements
- R1: The sync path is armed only by the code binary 10 on `ctl_code` (bit 1 high, bit 0 low). While the path is not armed, `gp_hs`, `gp_vs` and `gp_lclk` stay low.
- R2: A synchronous active-high reset clears `gp_hs`, `gp_vs` and `gp_lclk` to low, sets `dig_oe_n` high and leaves the path disarmed. The internal copy of the code resets to binary 11.
- R3: `dig_oe_n` goes low two clock edges after `ctl_code` becomes 10, and high two edges after it takes any other value. No vertical reset is needed for this.
- R4: A change of `ctl_code` arms or disarms the sync outputs only at the next rising edge of `dig_vreset`. Until then the previous arming state holds.
- R5: `dig_field` is sampled only at a rising edge of `dig_vreset`. A field is kept when the sampled value equals `KEEP_PARITY` (default 1) and the path is armed. Any other field is dropped. A change of `dig_field` while `dig_vreset` stays high does not alter that decision.
- R6: During a kept field, `gp_vs` follows `dig_vreset` and `gp_hs` follows `dig_hreset`. During a dropped field both stay low.
- R7: During a kept field, `gp_lclk` is high only when `dig_qclk`, `dig_dvalid` and `dig_active` are all high. During a dropped field it stays low.
- R8: Every output is registered. An input change appears on the outputs two rising clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_code | input | CTL_W | Arming code from the graphics controller |
| dig_vreset | input | 1 | Vertical reset strobe from the digitizer |
| dig_hreset | input | 1 | Horizontal reset strobe from the digitizer |
| dig_active | input | 1 | Active-video flag from the digitizer |
| dig_field | input | 1 | Field parity from the digitizer |
| dig_dvalid | input | 1 | Pixel data-valid flag from the digitizer |
| dig_qclk | input | 1 | Clock qualifier from the digitizer |
| gp_hs | output | 1 | Horizontal sync to the graphics port |
| gp_vs | output | 1 | Vertical sync to the graphics port |
| gp_lclk | output | 1 | Qualified line clock to the graphics port |
| dig_oe_n | output | 1 | Active-low output enable to the digitizer |

## Verification
The assertions assume that all digitizer strobes are synchronous to `clk`. They also assume that `ctl_code` holds steady for at least two edges around the change being judged, since the enable check looks two edges ahead. The stimulus holds each input pattern for three full clock cycles, with inputs changed only on the falling edge, so every pattern has settled through the two register stages before it is sampled. Vertical reset edges are created by separate low and high patterns. The parity change inside a high vertical reset is therefore the only case where the field flag moves without a new edge.

// File: rtl/fdg_pkg.sv
package fdg_pkg;

  // One sample of the digitizer timing strobes
  typedef struct packed {
    logic vreset;
    logic hreset;
    logic active;
    logic field;
    logic dvalid;
    logic qclk;
  } vid_t;

  localparam int VID_W = $bits(vid_t);

endpackage

// File: rtl/fdg_in_stage.sv
module fdg_in_stage
  import fdg_pkg::*;
#(
  parameter int CTL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  vid_t             vid_i,
  input  logic [CTL_W-1:0] ctl_i,
  output vid_t             vid_q,
  output logic [CTL_W-1:0] ctl_q,
  output logic             vr_rise
);

  logic vr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_q   <= '0;
      ctl_q   <= '1;
      vr_prev <= 1'b0;
    end else begin
      vid_q   <= vid_i;
      ctl_q   <= ctl_i;
      vr_prev <= vid_q.vreset;
    end
  end

  assign vr_rise = vid_q.vreset & ~vr_prev;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    vr_rise |=> !vr_rise); // R5

endmodule

// File: rtl/fdg_arm_ctrl.sv
module fdg_arm_ctrl #(
  parameter int               CTL_W       = 2,
  parameter logic [CTL_W-1:0] ENABLE_CODE = 2'b10,
  parameter logic             KEEP_PARITY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic             field_q,
  input  logic             vr_rise,
  output logic             pass_now,
  output logic             oe_n
);

  logic enable_hit;
  logic keep_now;
  logic armed;
  logic pass;

  assign enable_hit = (ctl_q == ENABLE_CODE);
  assign keep_now   = enable_hit && (field_q == KEEP_PARITY);
  assign pass_now   = vr_rise ? keep_now : pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      pass  <= 1'b0;
      oe_n  <= 1'b1;
    end else begin
      oe_n <= ~enable_hit;
      if (vr_rise) begin
        armed <= enable_hit;
        pass  <= keep_now;
      end
    end
  end

  AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !vr_rise |=> $stable(armed)); // R4
  AST_PARITY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !vr_rise |=> $stable(pass)); // R5
  AST_PASS_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    pass |-> armed); // R1

endmodule

// File: rtl/fdg_out_stage.sv
module fdg_out_stage
  import fdg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  vid_t vid_q,
  input  logic pass_now,
  output logic hs,
  output logic vs,
  output logic lclk
);

  logic pix_ok;
  assign pix_ok = vid_q.qclk & vid_q.dvalid & vid_q.active;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs   <= 1'b0;
      vs   <= 1'b0;
      lclk <= 1'b0;
    end else begin
      hs   <= pass_now & vid_q.hreset;
      vs   <= pass_now & vid_q.vreset;
      lclk <= pass_now & pix_ok;
    end
  end

  AST_LCLK_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    lclk |-> $past(vid_q.dvalid) && $past(vid_q.active)); // R7

endmodule

// File: rtl/field_drop_sync_gate.sv
module field_drop_sync_gate
  import fdg_pkg::*;
#(
  parameter int               CTL_W       = 2,
  parameter logic [CTL_W-1:0] ENABLE_CODE = 2'b10,
  parameter logic             KEEP_PARITY = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CTL_W-1:0] ctl_code,
  input  logic             dig_vreset,
  input  logic             dig_hreset,
  input  logic             dig_active,
  input  logic             dig_field,
  input  logic             dig_dvalid,
  input  logic             dig_qclk,
  output logic             gp_hs,
  output logic             gp_vs,
  output logic             gp_lclk,
  output logic             dig_oe_n
);

  vid_t             vid_i;
  vid_t             vid_q;
  logic [CTL_W-1:0] ctl_q;
  logic             vr_rise;
  logic             pass_now;

  assign vid_i = '{vreset: dig_vreset, hreset: dig_hreset, active: dig_active,
                   field: dig_field, dvalid: dig_dvalid, qclk: dig_qclk};

  fdg_in_stage #(.CTL_W(CTL_W)) u_in (
    .clk(clk), .rst(rst), .vid_i(vid_i), .ctl_i(ctl_code),
    .vid_q(vid_q), .ctl_q(ctl_q), .vr_rise(vr_rise)
  );

  fdg_arm_ctrl #(.CTL_W(CTL_W), .ENABLE_CODE(ENABLE_CODE), .KEEP_PARITY(KEEP_PARITY)) u_ctl (
    .clk(clk), .rst(rst), .ctl_q(ctl_q), .field_q(vid_q.field),
    .vr_rise(vr_rise), .pass_now(pass_now), .oe_n(dig_oe_n)
  );

  fdg_out_stage u_out (
    .clk(clk), .rst(rst), .vid_q(vid_q), .pass_now(pass_now),
    .hs(gp_hs), .vs(gp_vs), .lclk(gp_lclk)
  );

  AST_OE_ON: assert property (@(posedge clk) disable iff (rst)
    (ctl_code == ENABLE_CODE) |=> ##1 !dig_oe_n); // R3
  AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
    (ctl_code != ENABLE_CODE) |=> ##1 dig_oe_n); // R3
  AST_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !gp_hs && !gp_vs && !gp_lclk && dig_oe_n); // R2
  AST_VS_NEEDS_VRESET: assert property (@(posedge clk) disable iff (rst)
    gp_vs |-> $past(dig_vreset, 2)); // R6

endmodule

// File: tb/field_drop_sync_gate_bench.sv
`timescale 1ns/1ps
module field_drop_sync_gate_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ctl_code = 2'b11;
  logic       vr = 0, hr = 0, act = 0, fld = 0, dv = 0, qc = 0;
  logic       gp_hs, gp_vs, gp_lclk, dig_oe_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  field_drop_sync_gate u_field_drop_sync_gate (
    .clk(clk), .rst(rst), .ctl_code(ctl_code),
    .dig_vreset(vr), .dig_hreset(hr), .dig_active(act), .dig_field(fld),
    .dig_dvalid(dv), .dig_qclk(qc),
    .gp_hs(gp_hs), .gp_vs(gp_vs), .gp_lclk(gp_lclk), .dig_oe_n(dig_oe_n)
  );

  // {ctl[1:0], vr, hr, act, fld, dv, qc, exp_hs, exp_vs, exp_lclk, exp_oen}
  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    12'b11_011111_0001,  // 0  R1 idle code keeps outputs low
    12'b10_011011_0000,  // 1  R4 code 10 but no vreset yet; R3 oe low
    12'b10_100100_0100,  // 2  R5 odd field kept, vs forwarded
    12'b10_010100_1000,  // 3  R6 hs forwarded in kept field
    12'b10_001011_0010,  // 4  R7 line clock when all qualifiers high
    12'b10_001001_0000,  // 5  R7 no dvalid
    12'b10_000011_0000,  // 6  R7 no active
    12'b10_100000_0000,  // 7  R5 even field dropped
    12'b10_010000_0000,  // 8  R6 hs blanked in dropped field
    12'b10_001011_0000,  // 9  R7 lclk blanked in dropped field
    12'b10_100100_0100,  // 10 R5 next odd field kept
    12'b01_010000_1001,  // 11 R4 disable waits for vreset; R3 oe high
    12'b01_100100_0001,  // 12 R1 disarmed at vreset
    12'b01_011011_0001,  // 13 R1 all outputs stay low
    12'b00_000000_0001,  // 14 R1 another idle code
    12'b10_100100_0100,  // 15 R4 rearm on vreset edge
    12'b10_100000_0100,  // 16 R5 parity change without new edge ignored
    12'b10_010000_1000   // 17 R6 hs still forwarded
  };

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, got, exp);
    end
  endtask

  task automatic hold3();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2 reset state
    check("R2", "hs", gp_hs, 1'b0);
    check("R2", "vs", gp_vs, 1'b0);
    check("R2", "lclk", gp_lclk, 1'b0);
    check("R2", "oe_n", dig_oe_n, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {ctl_code, vr, hr, act, fld, dv, qc} = VEC[i][11:4];
      hold3();
      check($sformatf("vec%0d", i), "hs",   gp_hs,    VEC[i][3]);
      check($sformatf("vec%0d", i), "vs",   gp_vs,    VEC[i][2]);
      check($sformatf("vec%0d", i), "lclk", gp_lclk,  VEC[i][1]);
      check($sformatf("vec%0d", i), "oe_n", dig_oe_n, VEC[i][0]);
    end

    // R2 reset while armed clears everything
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2", "hs in reset", gp_hs, 1'b0);
    check("R2", "oe_n in reset", dig_oe_n, 1'b1);
    {vr, hr, act, fld, dv, qc} = 6'b010000;
    ctl_code = 2'b10;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    hold3();
    check("R2", "disarmed after reset, hs", gp_hs, 1'b0);
    check("R3", "oe follows code after reset", dig_oe_n, 1'b0);

    // R8 two-edge latency of a kept vsync
    {vr, hr} = 2'b10; fld = 1'b1;
    hold3();
    check("R5", "vs after rearm", gp_vs, 1'b1);
    vr = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R8", "vs one edge after drop", gp_vs, 1'b1);
    @(posedge clk); @(negedge clk);
    check("R8", "vs two edges after drop", gp_vs, 1'b0);
    hr = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8", "hs one edge after rise", gp_hs, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8", "hs two edges after rise", gp_hs, 1'b1);

    done = 1;
    summary();
    $finish;
  end

endmodule